// File: doc/BRIEF.md
# I2C Mailbox to Clause 45 MDIO Bridge

This block sits inside a pluggable module and gives a host a path to a Clause 45 PHY. The host cannot reach the PHY management bus directly, so it talks to a small byte register file through an I2C target front end. That front end is not part of this block. It presents the block with a 7-bit target address, a byte offset, write data and separate read and write strobes. The block answers only on target address 0x51. Its mailbox appears only after the host has selected page 3 and written an all-ones 32-bit password.

The host loads a 5-bit device address, a 16-bit register address and, for writes, a 16-bit value. It then writes a command byte. The block runs the access as an MDIO Clause 45 master on MDC/MDIO: first an address frame, then a write frame or a read frame. MDC runs at the core clock divided by `2*MDC_HALF`. While the access runs, the command byte reads back the code that started it. When the access completes, the command byte reads 0x04. The host polls the command byte until it sees that value. For a read, it then collects the result from the value bytes.

Top module: `mdio_mailbox_bridge`

## Requirements
- R1: Only target address 0x51 is decoded. A read on any other target address returns 0xFF one cycle after the read strobe, and a write on any other target address changes no state.
- R2: The page byte is at offset 0x7F and reads back its value. The password bytes are at offsets 0x7B to 0x7E; they can be written and always read 0xFF. The mailbox (offsets 0x80 to 0x85) is unlocked only while the page byte is 0x03 and all four password bytes are 0xFF. While locked, mailbox reads return 0xFF and mailbox writes are ignored. Reset leaves page and password at 0x00.
- R3: The command byte is at offset 0x80. Writing 0x01 starts an MDIO write and writing 0x02 starts an MDIO read. During the access the byte reads back the code that started it. After reset and after each completed access it reads 0x04.
- R4: A write to the command byte is ignored while the byte reads anything other than 0x04. When it reads 0x04, any value other than 0x01 or 0x02 is ignored and starts no frame.
- R5: Offset 0x81 holds the device address in bits 4:0. Bits 7:5 are dropped on write and read back as zero.
- R6: Offsets 0x82/0x83 hold the register address as high byte then low byte. Offsets 0x84/0x85 hold the value as high byte then low byte.
- R7: Every command issues two 64-bit frames, each sent MSB first. The address frame is 32 ones, ST 00, OP 00, port address `PRTAD`, device, TA 10, register address. The write frame is 32 ones, 00, OP 01, `PRTAD`, device, TA 10, value.
- R8: The read frame is 32 ones, 00, OP 11, `PRTAD`, device. The master then releases MDIO (`mdio_oe_o` low) for the 2 TA bits and 16 data bits. It samples the 16 data bits MSB first as MDC rises, and stores them in offsets 0x84/0x85 before the command byte reads 0x04.
- R9: While idle, MDC is low and `mdio_oe_o` is low. While busy, MDC has a period of `2*MDC_HALF` clocks, and `mdio_o` changes only while MDC is low.
- R10: Reads of offsets on target address 0x51 other than 0x7F and 0x80 to 0x85 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| i2c_dev_i | input | 7 | I2C target address of the current access |
| reg_addr_i | input | 8 | Byte offset |
| reg_wdata_i | input | 8 | Write data |
| reg_we_i | input | 1 | Write strobe, one cycle per byte |
| reg_re_i | input | 1 | Read strobe, one cycle per byte |
| reg_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| mdc_o | output | 1 | MDIO clock |
| mdio_o | output | 1 | MDIO data out |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data in |

## Verification
The bench builds the block with `MDC_HALF = 2` and `PRTAD = 5'h0A`. With these values a full two-frame command takes about 512 clocks, so a command can be polled to completion in a few hundred register reads. The port address is non-zero and distinct from the device fields used, so a swapped or dropped field in a captured frame shows up. A behavioural PHY on MDC captures every frame bit with its output-enable state and measures the MDC period. For OP 11 frames it drives a chosen word back, which lets the bench check the MDIO turnaround window and the read-back path against the mailbox bytes.

// File: rtl/mdio_mbx_pkg.sv
package mdio_mbx_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned IDX_W = $clog2(FRAME_BITS);
  localparam int unsigned PW_BYTES = 4;

  localparam logic [6:0]    MBX_I2C_ADDR = 7'h51;
  localparam logic [AW-1:0] OFS_PW0  = 8'h7B;
  localparam logic [AW-1:0] OFS_PAGE = 8'h7F;
  localparam logic [AW-1:0] OFS_CMD  = 8'h80;
  localparam logic [AW-1:0] OFS_DEV  = 8'h81;
  localparam logic [AW-1:0] OFS_REGH = 8'h82;
  localparam logic [AW-1:0] OFS_REGL = 8'h83;
  localparam logic [AW-1:0] OFS_VALH = 8'h84;
  localparam logic [AW-1:0] OFS_VALL = 8'h85;

  localparam logic [DW-1:0] MBX_PAGE = 8'h03;
  localparam logic [DW-1:0] CMD_WR   = 8'h01;
  localparam logic [DW-1:0] CMD_RD   = 8'h02;
  localparam logic [DW-1:0] CMD_DONE = 8'h04;

  localparam logic [31:0] PREAMBLE = 32'hFFFF_FFFF;
  localparam logic [1:0]  ST_C45   = 2'b00;
  localparam logic [1:0]  OP_ADDR  = 2'b00;
  localparam logic [1:0]  OP_WRITE = 2'b01;
  localparam logic [1:0]  OP_READ  = 2'b11;
  localparam logic [1:0]  TA_DRV   = 2'b10;
  // first bit index of the released read window (TA + data)
  localparam logic [IDX_W-1:0] RD_REL_IDX  = IDX_W'(46);
  localparam logic [IDX_W-1:0] RD_DATA_IDX = IDX_W'(48);
endpackage

// File: rtl/mdc_clock_gen.sv
module mdc_clock_gen #(
  parameter int unsigned HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == LAST);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_mbx_pkg::*;
#(
  parameter logic [4:0] PRTAD = 5'h00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        is_read_i,
  input  logic [4:0]  dev_i,
  input  logic [15:0] reg_i,
  input  logic [15:0] wval_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rval_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [FRAME_BITS-1:0] shreg_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  busy_q, second_q, rd_q;
  logic [4:0]            dev_q;
  logic [15:0]           wval_q, rdat_q;
  logic                  last_bit;

  assign last_bit  = fall_i && (idx_q == IDX_W'(FRAME_BITS - 1));
  assign done_o    = busy_q && second_q && last_bit;
  assign busy_o    = busy_q;
  assign rval_o    = rdat_q;
  assign mdio_o    = busy_q ? shreg_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o = busy_q && !(second_q && rd_q && idx_q >= RD_REL_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q  <= '1;
      idx_q    <= '0;
      busy_q   <= 1'b0;
      second_q <= 1'b0;
      rd_q     <= 1'b0;
      dev_q    <= '0;
      wval_q   <= '0;
      rdat_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q   <= 1'b1;
      second_q <= 1'b0;
      rd_q     <= is_read_i;
      idx_q    <= '0;
      dev_q    <= dev_i;
      wval_q   <= wval_i;
      shreg_q  <= {PREAMBLE, ST_C45, OP_ADDR, PRTAD, dev_i, TA_DRV, reg_i};
    end else if (busy_q) begin
      if (rise_i && second_q && rd_q && idx_q >= RD_DATA_IDX)
        rdat_q <= {rdat_q[14:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          idx_q <= '0;
          if (second_q) begin
            busy_q <= 1'b0;
          end else begin
            second_q <= 1'b1;
            shreg_q  <= rd_q ? {PREAMBLE, ST_C45, OP_READ, PRTAD, dev_q, 2'b11, 16'hFFFF}
                             : {PREAMBLE, ST_C45, OP_WRITE, PRTAD, dev_q, TA_DRV, wval_q};
          end
        end else begin
          idx_q   <= idx_q + IDX_W'(1);
          shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mbx_regs.sv
module mdio_mbx_regs
  import mdio_mbx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [6:0]    i2c_dev_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          done_i,
  input  logic [15:0]   rval_i,
  output logic          start_o,
  output logic          is_read_o,
  output logic [4:0]    dev_o,
  output logic [15:0]   reg_o,
  output logic [15:0]   wval_o
);
  logic [DW-1:0]               page_q, cmd_q, rdata_q, rd_mux;
  logic [PW_BYTES-1:0][DW-1:0] pw_q;
  logic [4:0]                  dev_q;
  logic [15:0]                 reg_q, val_q;
  logic                        hit, unlocked, mbx_we;

  assign hit       = (i2c_dev_i == MBX_I2C_ADDR);
  assign unlocked  = (page_q == MBX_PAGE) && (&pw_q);
  assign mbx_we    = reg_we_i && hit && unlocked;
  assign start_o   = mbx_we && (reg_addr_i == OFS_CMD) && (cmd_q == CMD_DONE) &&
                     ((reg_wdata_i == CMD_WR) || (reg_wdata_i == CMD_RD));
  assign is_read_o = (reg_wdata_i == CMD_RD);
  assign dev_o     = dev_q;
  assign reg_o     = reg_q;
  assign wval_o    = val_q;
  assign reg_rdata_o = rdata_q;

  always_comb begin
    rd_mux = 8'hFF;
    if (hit) begin
      if (reg_addr_i == OFS_PAGE) begin
        rd_mux = page_q;
      end else if (unlocked) begin
        case (reg_addr_i)
          OFS_CMD:  rd_mux = cmd_q;
          OFS_DEV:  rd_mux = {3'b000, dev_q};
          OFS_REGH: rd_mux = reg_q[15:8];
          OFS_REGL: rd_mux = reg_q[7:0];
          OFS_VALH: rd_mux = val_q[15:8];
          OFS_VALL: rd_mux = val_q[7:0];
          default:  rd_mux = 8'hFF;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q  <= '0;
      pw_q    <= '0;
      cmd_q   <= CMD_DONE;
      dev_q   <= '0;
      reg_q   <= '0;
      val_q   <= '0;
      rdata_q <= 8'hFF;
    end else begin
      if (reg_re_i) rdata_q <= rd_mux;
      if (reg_we_i && hit) begin
        if (reg_addr_i == OFS_PAGE) page_q <= reg_wdata_i;
        for (int i = 0; i < PW_BYTES; i++)
          if (reg_addr_i == OFS_PW0 + AW'(i)) pw_q[i] <= reg_wdata_i;
      end
      if (mbx_we) begin
        case (reg_addr_i)
          OFS_DEV:  dev_q        <= reg_wdata_i[4:0];
          OFS_REGH: reg_q[15:8]  <= reg_wdata_i;
          OFS_REGL: reg_q[7:0]   <= reg_wdata_i;
          OFS_VALH: val_q[15:8]  <= reg_wdata_i;
          OFS_VALL: val_q[7:0]   <= reg_wdata_i;
          default: ;
        endcase
      end
      if (start_o) cmd_q <= reg_wdata_i;
      // completion overrides a same-cycle host write to the value bytes
      if (done_i) begin
        cmd_q <= CMD_DONE;
        if (cmd_q == CMD_RD) val_q <= rval_i;
      end
    end
  end
endmodule

// File: rtl/mdio_mailbox_bridge.sv
module mdio_mailbox_bridge
  import mdio_mbx_pkg::*;
#(
  parameter int unsigned MDC_HALF = 4,
  parameter logic [4:0]  PRTAD    = 5'h00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [6:0]    i2c_dev_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          mdc_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic          mdio_i
);
  logic        start, is_read, busy, done, rise, fall;
  logic [4:0]  dev;
  logic [15:0] regad, wval, rval;

  mdio_mbx_regs u_regs (
    .clk_i, .rst_ni, .i2c_dev_i, .reg_addr_i, .reg_wdata_i, .reg_we_i, .reg_re_i,
    .reg_rdata_o,
    .done_i(done), .rval_i(rval), .start_o(start), .is_read_o(is_read),
    .dev_o(dev), .reg_o(regad), .wval_o(wval)
  );

  mdc_clock_gen #(.HALF(MDC_HALF)) u_mdc (
    .clk_i, .rst_ni, .run_i(busy), .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_c45_master #(.PRTAD(PRTAD)) u_master (
    .clk_i, .rst_ni, .start_i(start), .is_read_i(is_read), .dev_i(dev),
    .reg_i(regad), .wval_i(wval), .rise_i(rise), .fall_i(fall), .mdio_i,
    .busy_o(busy), .done_o(done), .rval_o(rval), .mdio_o, .mdio_oe_o
  );
endmodule

// File: rtl/mdio_mbx_chk.sv
module mdio_mbx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       mdc_i,
  input logic       mdio_out_i,
  input logic       mdio_oe_i,
  input logic [6:0] dev_i,
  input logic [7:0] addr_i,
  input logic       we_i,
  input logic       re_i,
  input logic [7:0] rdata_i
);
  // R9
  idle_bus_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !mdio_oe_i));
  // R9
  mdio_change_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !$stable(mdio_out_i)) |-> !mdc_i);
  // R1
  foreign_dev_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && dev_i != 7'h51) |=> (rdata_i == 8'hFF));
  // R10
  unused_ofs_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (addr_i < 8'h7B || addr_i > 8'h85)) |=> (rdata_i == 8'hFF));
  // R4
  no_spurious_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !(we_i && dev_i == 7'h51 && addr_i == 8'h80)) |=> !busy_i);
endmodule

bind mdio_mailbox_bridge mdio_mbx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .mdc_i(mdc_o),
  .mdio_out_i(mdio_o), .mdio_oe_i(mdio_oe_o), .dev_i(i2c_dev_i),
  .addr_i(reg_addr_i), .we_i(reg_we_i), .re_i(reg_re_i), .rdata_i(reg_rdata_o)
);

// File: tb/mdio_mailbox_bridge_test.sv
`timescale 1ns/1ps
module mdio_mailbox_bridge_test;
  localparam int unsigned HALF = 2;
  localparam logic [4:0]  PRT  = 5'h0A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] dev = 7'h51;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic we = 1'b0, re = 1'b0;
  logic mdc, mdio_out, mdio_oe, mdio_in = 1'b1;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mdio_mailbox_bridge #(.MDC_HALF(HALF), .PRTAD(PRT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .i2c_dev_i(dev), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_we_i(we), .reg_re_i(re), .reg_rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  // behavioural PHY
  int k = 0, frames = 0;
  logic [63:0] cap, oecap, a_frame, d_frame, d_oe;
  logic [15:0] phy_val = 16'h0000;
  realtime last_rise = 0, mdc_period = 0;
  always @(posedge mdc) begin
    if (last_rise > 0) mdc_period = $realtime - last_rise;
    last_rise = $realtime;
    cap[63-k] = mdio_out;
    oecap[63-k] = mdio_oe;
    mdio_in = 1'b1;
    if ((frames % 2) == 1 && k >= 3 && cap[61:60] == 2'b11 && k + 1 >= 48 && k + 1 <= 63)
      mdio_in = phy_val[63-(k+1)];
    k++;
    if (k == 64) begin
      k = 0;
      if ((frames % 2) == 0) a_frame = cap;
      else begin d_frame = cap; d_oe = oecap; end
      frames++;
      last_rise = 0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] d, input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); dev = d; addr = a; wdata = v; we = 1'b1;
    @(negedge clk); we = 1'b0; dev = 7'h51;
  endtask

  task automatic rd(input logic [6:0] d, input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); dev = d; addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; v = rdata; dev = 7'h51;
  endtask

  task automatic unlock();
    wr(7'h51, 8'h7F, 8'h03);
    for (int i = 0; i < 4; i++) wr(7'h51, 8'h7B + 8'(i), 8'hFF);
  endtask

  task automatic wait_done(input string req);
    logic [7:0] v;
    v = 8'h00;
    for (int i = 0; i < 4000 && v != 8'h04; i++) rd(7'h51, 8'h80, v);
    chk({req, " completion"}, v, 8'h04);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(7'h51, 8'h7F, v); chk("R2 page reset", v, 8'h00);
    rd(7'h51, 8'h80, v); chk("R2 locked after reset", v, 8'hFF);
    chk("R9 idle mdc/oe", {mdc, mdio_oe}, 2'b00);
  endtask

  task automatic t_lock();
    logic [7:0] v;
    wr(7'h51, 8'h7F, 8'h03);
    wr(7'h51, 8'h7B, 8'hFF); wr(7'h51, 8'h7C, 8'hFF); wr(7'h51, 8'h7D, 8'hFF);
    wr(7'h51, 8'h7E, 8'hFE);
    rd(7'h51, 8'h80, v); chk("R2 wrong password locked", v, 8'hFF);
    wr(7'h51, 8'h81, 8'h09);
    wr(7'h51, 8'h7E, 8'hFF);
    rd(7'h51, 8'h80, v); chk("R3 unlocked cmd reads done", v, 8'h04);
    rd(7'h51, 8'h81, v); chk("R2 locked write ignored", v, 8'h00);
    rd(7'h51, 8'h7C, v); chk("R2 password reads FF", v, 8'hFF);
    rd(7'h51, 8'h7F, v); chk("R2 page readback", v, 8'h03);
  endtask

  task automatic t_foreign();
    logic [7:0] v;
    rd(7'h50, 8'h7F, v); chk("R1 foreign read", v, 8'hFF);
    wr(7'h50, 8'h7F, 8'h00);
    wr(7'h50, 8'h81, 8'h05);
    rd(7'h51, 8'h7F, v); chk("R1 foreign page write ignored", v, 8'h03);
    rd(7'h51, 8'h81, v); chk("R1 foreign mailbox write ignored", v, 8'h00);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    rd(7'h51, 8'h86, v); chk("R10 offset 0x86", v, 8'hFF);
    rd(7'h51, 8'h00, v); chk("R10 offset 0x00", v, 8'hFF);
  endtask

  task automatic t_dev();
    logic [7:0] v;
    wr(7'h51, 8'h81, 8'hFF);
    rd(7'h51, 8'h81, v); chk("R5 device masked", v, 8'h1F);
  endtask

  task automatic t_mdio_write();
    logic [7:0] v;
    int f0;
    wr(7'h51, 8'h81, 8'h07);
    wr(7'h51, 8'h82, 8'h12); wr(7'h51, 8'h83, 8'h34);
    wr(7'h51, 8'h84, 8'hBE); wr(7'h51, 8'h85, 8'hEF);
    rd(7'h51, 8'h82, v); chk("R6 reg high byte", v, 8'h12);
    rd(7'h51, 8'h85, v); chk("R6 value low byte", v, 8'hEF);
    f0 = frames;
    wr(7'h51, 8'h80, 8'h01);
    rd(7'h51, 8'h80, v); chk("R3 busy reads write code", v, 8'h01);
    wr(7'h51, 8'h80, 8'h02);
    rd(7'h51, 8'h80, v); chk("R4 busy cmd write ignored", v, 8'h01);
    wait_done("R3 write");
    chk("R7 two frames", 64'(frames - f0), 64'd2);
    chk("R7 address frame", a_frame, {32'hFFFFFFFF, 2'b00, 2'b00, PRT, 5'h07, 2'b10, 16'h1234});
    chk("R7 write frame", d_frame, {32'hFFFFFFFF, 2'b00, 2'b01, PRT, 5'h07, 2'b10, 16'hBEEF});
    chk("R7 write frame driven", d_oe, 64'hFFFFFFFF_FFFFFFFF);
    chk("R9 mdc period ns", 64'($rtoi(mdc_period * 10)), 64'(2 * HALF * 50));
    chk("R9 idle after done", {mdc, mdio_oe}, 2'b00);
  endtask

  task automatic t_mdio_read();
    logic [7:0] v;
    phy_val = 16'h5A3C;
    wr(7'h51, 8'h81, 8'h1F);
    wr(7'h51, 8'h82, 8'hFF); wr(7'h51, 8'h83, 8'hFE);
    wr(7'h51, 8'h80, 8'h02);
    rd(7'h51, 8'h80, v); chk("R3 busy reads read code", v, 8'h02);
    wait_done("R8 read");
    chk("R7 read address frame", a_frame, {32'hFFFFFFFF, 2'b00, 2'b00, PRT, 5'h1F, 2'b10, 16'hFFFE});
    chk("R8 read frame header", 64'(d_frame[63:18]), 64'({32'hFFFFFFFF, 2'b00, 2'b11, PRT, 5'h1F}));
    chk("R8 release window", d_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
    rd(7'h51, 8'h84, v); chk("R8 read data high", v, 8'h5A);
    rd(7'h51, 8'h85, v); chk("R8 read data low", v, 8'h3C);
  endtask

  task automatic t_bad_cmd();
    logic [7:0] v;
    int f0;
    f0 = frames;
    wr(7'h51, 8'h80, 8'h03);
    rd(7'h51, 8'h80, v); chk("R4 invalid code ignored", v, 8'h04);
    repeat (300) @(negedge clk);
    chk("R4 no frame for invalid code", 64'(frames), 64'(f0));
    chk("R4 bus idle", {mdc, mdio_oe}, 2'b00);
  endtask

  task automatic t_relock();
    logic [7:0] v;
    wr(7'h51, 8'h7F, 8'h00);
    rd(7'h51, 8'h84, v); chk("R2 relocked by page", v, 8'hFF);
    wr(7'h51, 8'h7F, 8'h03);
    rd(7'h51, 8'h84, v); chk("R2 reopened keeps data", v, 8'h5A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lock();
    t_foreign();
    t_unused();
    t_dev();
    t_mdio_write();
    t_mdio_read();
    t_bad_cmd();
    t_relock();
    unlock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule